// File: doc/BRIEF.md
# Completion Interrupt Coalescer

This unit decides when a descriptor-driven engine should tell the host that work has finished. A ring tracker supplies `done_cnt`, the number of descriptors that have completed but that software has not yet handed back. The unit sends one interrupt for a batch of completions rather than one per descriptor. It fires when that count reaches a programmed limit. It can also fire when an optional timeout runs out while completions are still waiting, so that a small batch is not held back for ever.

The interrupt is sent as a memory write, not as a level wire. When the unit fires, it captures a programmed 48-bit address and a 32-bit payload and presents them on a request/acknowledge handshake. It keeps them there until the receiver takes them. Software sets the limit, the timer and the message fields through a small register port with a write strobe and a combinational read path. Once a message has gone out, the unit stays quiet until the count changes. That happens when software releases descriptors or when more completions arrive.

Top module: `irq_coalescer`

## Requirements
- R1: After reset `msg_req` is 0, `msg_addr` and `msg_data` are 0, and every register reads back 0. This leaves the count limit at 0, the timer disabled and the timeout at 0.
- R2: Register layout, read back combinationally from `reg_rdata` for the value on `reg_addr`:
  - 0x00 is the count limit in bits [14:0] and the timer enable in bit 18. All other bits read 0.
  - 0x04 is the timeout in bits [12:0].
  - 0x08 is the low 32 bits of the message address.
  - 0x0C is the high address part. Only bits [15:0] are kept.
  - 0x10 is the 32-bit payload.
  - Any other offset reads 0.
- R3: When `done_cnt` is nonzero and at or above the count limit, no request is outstanding and the unit is not quiet, `msg_req` is 1 after the next clock edge.
- R4: No message is ever sent while `done_cnt` is 0. This holds even with a limit of 0, the timer enabled and a timeout of 0.
- R5: With the timer enabled, a nonzero count below the limit that is applied while the count was 0 makes `msg_req` rise after exactly timeout+1 clock edges.
- R6: With the timer disabled, a nonzero count below the limit never causes a message, however long it is held.
- R7: The timer restarts whenever `done_cnt` returns to 0. Time counted before that is lost.
- R8: After a message, no further message is sent while `done_cnt` keeps the value it had when the message fired. Any change of the count re-arms the unit, whether the count goes down (release) or up (new completions).
- R9: While `msg_req` is 1 and `msg_ack` is 0, `msg_addr` ({high[15:0], low[31:0]}) and `msg_data` stay at the values captured when the message fired. Register writes made in that time do not change them.
- R10: Only one request is outstanding. `msg_req` falls on the edge where it is acknowledged and is 0 for at least one cycle before the next request.
- R11: When the count limit and the timeout are met in the same cycle, exactly one message is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| done_cnt | input | 15 | Completed-but-unreleased descriptor count |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 48 | Message write address |
| msg_data | output | 32 | Message write payload |
| msg_ack | input | 1 | Receiver accepts the request |

## Verification
The count path and the timeout path can both become true in the same cycle. The bench provokes this by enabling the timer with a timeout of 0 and then moving the count from 0 straight to the limit. It judges the result by requiring a single request that is accepted, then several quiet cycles with no second request.

A second overlap is a change of the count while a request is still waiting for its acknowledge. The bench checks that the new request appears only on the cycle after the old one has fallen.

// File: rtl/ic_pkg.sv
`timescale 1ns/1ps
package ic_pkg;
  // field widths and positions fixed by the register layout
  localparam int CNT_W  = 15;
  localparam int TMO_W  = 13;
  localparam int HI_W   = 16;
  localparam int WORD_W = 32;
  localparam int EN_BIT = 18;
  localparam int RA_W   = 8;

  localparam logic [RA_W-1:0] OFF_LIMIT = 8'h00;
  localparam logic [RA_W-1:0] OFF_TMO   = 8'h04;
  localparam logic [RA_W-1:0] OFF_ALO   = 8'h08;
  localparam logic [RA_W-1:0] OFF_AHI   = 8'h0C;
  localparam logic [RA_W-1:0] OFF_DATA  = 8'h10;

  // count path: a nonzero count at or above the limit
  function automatic logic count_met(input logic [CNT_W-1:0] cnt,
                                     input logic [CNT_W-1:0] lim);
    return (cnt != '0) && (cnt >= lim);
  endfunction

  // saturating step of the wait timer
  function automatic logic [TMO_W-1:0] timer_step(input logic [TMO_W-1:0] t,
                                                  input logic [TMO_W-1:0] lim);
    return (t >= lim) ? t : t + 1'b1;
  endfunction

  // read view of the limit register
  function automatic logic [WORD_W-1:0] limit_view(input logic [CNT_W-1:0] lim,
                                                   input logic en);
    logic [WORD_W-1:0] w;
    w = '0;
    w[CNT_W-1:0] = lim;
    w[EN_BIT] = en;
    return w;
  endfunction
endpackage

// File: rtl/ic_regs.sv
`timescale 1ns/1ps
module ic_regs
  import ic_pkg::*;
#(
  parameter int P_CNT_W = CNT_W,
  parameter int P_TMO_W = TMO_W,
  parameter int P_HI_W  = HI_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr,
  input  logic [RA_W-1:0]     addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic [P_CNT_W-1:0]  limit,
  output logic                tmr_en,
  output logic [P_TMO_W-1:0]  tmo,
  output logic [WORD_W-1:0]   addr_lo,
  output logic [P_HI_W-1:0]   addr_hi,
  output logic [WORD_W-1:0]   payload
);
  logic sel_lim, sel_tmo, sel_alo, sel_ahi, sel_dat;

  assign sel_lim = (addr == OFF_LIMIT);
  assign sel_tmo = (addr == OFF_TMO);
  assign sel_alo = (addr == OFF_ALO);
  assign sel_ahi = (addr == OFF_AHI);
  assign sel_dat = (addr == OFF_DATA);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit   <= '0;
      tmr_en  <= 1'b0;
      tmo     <= '0;
      addr_lo <= '0;
      addr_hi <= '0;
      payload <= '0;
    end else if (wr) begin
      if (sel_lim) begin
        limit  <= wdata[P_CNT_W-1:0];
        tmr_en <= wdata[EN_BIT];
      end
      if (sel_tmo) tmo     <= wdata[P_TMO_W-1:0];
      if (sel_alo) addr_lo <= wdata;
      if (sel_ahi) addr_hi <= wdata[P_HI_W-1:0];
      if (sel_dat) payload <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_lim) rdata = limit_view(limit, tmr_en);
    if (sel_tmo) rdata[P_TMO_W-1:0] = tmo;
    if (sel_alo) rdata = addr_lo;
    if (sel_ahi) rdata[P_HI_W-1:0] = addr_hi;
    if (sel_dat) rdata = payload;
  end
endmodule

// File: rtl/ic_timer.sv
`timescale 1ns/1ps
module ic_timer
  import ic_pkg::*;
#(
  parameter int P_CNT_W = CNT_W,
  parameter int P_TMO_W = TMO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_CNT_W-1:0] done_cnt,
  input  logic [P_TMO_W-1:0] tmo,
  input  logic               restart,
  output logic               expired
);
  logic [P_TMO_W-1:0] elapsed;

  always_ff @(posedge clk) begin
    if (!rst_n)                           elapsed <= '0;
    else if (restart || done_cnt == '0)   elapsed <= '0;
    else                                  elapsed <= timer_step(elapsed, tmo);
  end

  assign expired = (elapsed >= tmo);
endmodule

// File: rtl/ic_decide.sv
`timescale 1ns/1ps
module ic_decide
  import ic_pkg::*;
#(
  parameter int P_CNT_W = CNT_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P_CNT_W-1:0] done_cnt,
  input  logic [P_CNT_W-1:0] limit,
  input  logic               tmr_en,
  input  logic               tmr_expired,
  input  logic               busy,
  output logic               fire,
  output logic               quiet
);
  logic               quiet_q;
  logic [P_CNT_W-1:0] snap_q;
  logic               want;

  // stays quiet only while the count holds its value from the last fire
  assign quiet = quiet_q && (done_cnt == snap_q);
  assign want  = count_met(done_cnt, limit) ||
                 (tmr_en && tmr_expired && done_cnt != '0);
  assign fire  = want && !busy && !quiet;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quiet_q <= 1'b0;
      snap_q  <= '0;
    end else if (fire) begin
      quiet_q <= 1'b1;
      snap_q  <= done_cnt;
    end else if (done_cnt != snap_q) begin
      quiet_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ic_msg.sv
`timescale 1ns/1ps
module ic_msg
  import ic_pkg::*;
#(
  parameter int P_HI_W = HI_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fire,
  input  logic [WORD_W-1:0]        addr_lo,
  input  logic [P_HI_W-1:0]        addr_hi,
  input  logic [WORD_W-1:0]        payload,
  input  logic                     ack,
  output logic                     req,
  output logic [P_HI_W+WORD_W-1:0] addr,
  output logic [WORD_W-1:0]        data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req  <= 1'b0;
      addr <= '0;
      data <= '0;
    end else if (fire) begin
      req  <= 1'b1;
      addr <= {addr_hi, addr_lo};
      data <= payload;
    end else if (req && ack) begin
      req  <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_coalescer.sv
`timescale 1ns/1ps
module irq_coalescer
  import ic_pkg::*;
#(
  parameter int P_CNT_W = CNT_W,
  parameter int P_TMO_W = TMO_W,
  parameter int P_HI_W  = HI_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reg_wr,
  input  logic [RA_W-1:0]          reg_addr,
  input  logic [WORD_W-1:0]        reg_wdata,
  output logic [WORD_W-1:0]        reg_rdata,
  input  logic [P_CNT_W-1:0]       done_cnt,
  output logic                     msg_req,
  output logic [P_HI_W+WORD_W-1:0] msg_addr,
  output logic [WORD_W-1:0]        msg_data,
  input  logic                     msg_ack
);
  logic [P_CNT_W-1:0] limit;
  logic               tmr_en;
  logic [P_TMO_W-1:0] tmo;
  logic [WORD_W-1:0]  addr_lo;
  logic [P_HI_W-1:0]  addr_hi;
  logic [WORD_W-1:0]  payload;
  logic               tmr_expired;
  logic               fire;
  logic               quiet;

  ic_regs #(.P_CNT_W(P_CNT_W), .P_TMO_W(P_TMO_W), .P_HI_W(P_HI_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .limit(limit), .tmr_en(tmr_en), .tmo(tmo),
    .addr_lo(addr_lo), .addr_hi(addr_hi), .payload(payload)
  );

  ic_timer #(.P_CNT_W(P_CNT_W), .P_TMO_W(P_TMO_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .done_cnt(done_cnt), .tmo(tmo),
    .restart(fire || quiet), .expired(tmr_expired)
  );

  ic_decide #(.P_CNT_W(P_CNT_W)) u_decide (
    .clk(clk), .rst_n(rst_n), .done_cnt(done_cnt), .limit(limit),
    .tmr_en(tmr_en), .tmr_expired(tmr_expired), .busy(msg_req),
    .fire(fire), .quiet(quiet)
  );

  ic_msg #(.P_HI_W(P_HI_W)) u_msg (
    .clk(clk), .rst_n(rst_n), .fire(fire), .addr_lo(addr_lo),
    .addr_hi(addr_hi), .payload(payload), .ack(msg_ack),
    .req(msg_req), .addr(msg_addr), .data(msg_data)
  );
endmodule

// File: rtl/ic_chk.sv
`timescale 1ns/1ps
module ic_chk #(
  parameter int P_CNT_W = 15,
  parameter int AW = 48,
  parameter int DW = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [P_CNT_W-1:0] done_cnt,
  input logic [P_CNT_W-1:0] limit,
  input logic               tmr_en,
  input logic               tmr_expired,
  input logic               quiet,
  input logic               fire,
  input logic               msg_req,
  input logic               msg_ack,
  input logic [AW-1:0]      msg_addr,
  input logic [DW-1:0]      msg_data
);
  // R3
  count_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_req && !quiet && done_cnt != 0 && done_cnt >= limit) |=> msg_req);

  // R4
  zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_req) |-> ($past(done_cnt) != 0));

  // R5
  timer_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && done_cnt < limit) |-> (tmr_en && tmr_expired));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && !msg_ack) |=> (msg_req && $stable(msg_addr) && $stable(msg_data)));

  // R10
  single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && msg_ack) |=> !msg_req);
endmodule

bind irq_coalescer ic_chk #(.P_CNT_W(P_CNT_W), .AW(P_HI_W + 32), .DW(32)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_cnt(done_cnt), .limit(limit),
  .tmr_en(tmr_en), .tmr_expired(tmr_expired), .quiet(quiet), .fire(fire),
  .msg_req(msg_req), .msg_ack(msg_ack), .msg_addr(msg_addr), .msg_data(msg_data)
);

// File: tb/sim_irq_coalescer.sv
`timescale 1ns/1ps
module sim_irq_coalescer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [14:0] done_cnt = '0;
  logic        msg_req;
  logic [47:0] msg_addr;
  logic [31:0] msg_data;
  logic        msg_ack = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  irq_coalescer u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done_cnt(done_cnt),
    .msg_req(msg_req), .msg_addr(msg_addr), .msg_data(msg_data), .msg_ack(msg_ack)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic ack();
    msg_ack = 1'b1; tick(); msg_ack = 1'b0;
  endtask

  // {limit[14:0], count[14:0], expect_request}
  localparam logic [30:0] VEC [8] = '{
    {15'd20,    15'd19,    1'b0},
    {15'd20,    15'd20,    1'b1},
    {15'd20,    15'd21,    1'b1},
    {15'd0,     15'd0,     1'b0},
    {15'd1,     15'd1,     1'b1},
    {15'h7FFF,  15'h7FFF,  1'b1},
    {15'h7FFF,  15'h7FFE,  1'b0},
    {15'd3,     15'd2,     1'b0}
  };

  initial begin
    logic [31:0] v;
    tick(); tick(); tick();
    // R1: state during and after reset
    check("R1 req", {63'd0, msg_req}, 64'd0);
    rst_n = 1'b1;
    tick();
    check("R1 req", {63'd0, msg_req}, 64'd0);
    check("R1 addr", {16'd0, msg_addr}, 64'd0);
    check("R1 data", {32'd0, msg_data}, 64'd0);
    for (int i = 0; i < 5; i++) begin
      rd(8'(i * 4), v);
      check("R1 reg", {32'd0, v}, 64'd0);
    end

    // R2: field masks and unmapped offsets
    for (int i = 0; i < 5; i++) wr(8'(i * 4), 32'hFFFF_FFFF);
    rd(8'h00, v); check("R2 limit", {32'd0, v}, 64'h0004_7FFF);
    rd(8'h04, v); check("R2 tmo",   {32'd0, v}, 64'h0000_1FFF);
    rd(8'h08, v); check("R2 alo",   {32'd0, v}, 64'hFFFF_FFFF);
    rd(8'h0C, v); check("R2 ahi",   {32'd0, v}, 64'h0000_FFFF);
    rd(8'h10, v); check("R2 data",  {32'd0, v}, 64'hFFFF_FFFF);
    rd(8'h14, v); check("R2 unmapped", {32'd0, v}, 64'd0);
    for (int i = 0; i < 5; i++) wr(8'(i * 4), 32'h0);

    // R3: count-limit table with the timer off
    for (int i = 0; i < 8; i++) begin
      wr(8'h00, {17'd0, VEC[i][30:16]});
      done_cnt = VEC[i][15:1];
      tick();
      check("R3 table", {63'd0, msg_req}, {63'd0, VEC[i][0]});
      if (msg_req) begin
        ack();
        check("R10 drop", {63'd0, msg_req}, 64'd0);
      end
      done_cnt = '0;
      tick();
    end

    // R9: captured address/data hold while unacknowledged
    wr(8'h00, 32'd2);
    wr(8'h08, 32'hCAFE_0001);
    wr(8'h0C, 32'hABCD_1234);
    wr(8'h10, 32'h0000_55AA);
    done_cnt = 15'd3;
    tick();
    check("R9 req", {63'd0, msg_req}, 64'd1);
    check("R9 addr", {16'd0, msg_addr}, 64'h1234_CAFE_0001);
    check("R9 data", {32'd0, msg_data}, 64'h55AA);
    wr(8'h08, 32'h1111_1111);
    wr(8'h0C, 32'h2222);
    wr(8'h10, 32'h3333_3333);
    check("R9 addr hold", {16'd0, msg_addr}, 64'h1234_CAFE_0001);
    check("R9 data hold", {32'd0, msg_data}, 64'h55AA);
    check("R9 req hold", {63'd0, msg_req}, 64'd1);
    ack();
    done_cnt = '0; tick();

    // R10: count changes while busy; next request waits for the drop
    done_cnt = 15'd3; tick();
    check("R10 first", {63'd0, msg_req}, 64'd1);
    check("R10 new addr", {16'd0, msg_addr}, 64'h2222_1111_1111);
    done_cnt = 15'd4; tick();
    check("R10 busy", {63'd0, msg_req}, 64'd1);
    ack();
    check("R10 gap", {63'd0, msg_req}, 64'd0);
    tick();
    check("R10 next", {63'd0, msg_req}, 64'd1);
    ack();
    done_cnt = '0; tick();

    // R8: quiet until the count changes, timer cannot bypass it
    done_cnt = 15'd5; tick();
    check("R8 fire", {63'd0, msg_req}, 64'd1);
    ack();
    wr(8'h04, 32'd1);
    wr(8'h00, 32'h0004_0002);
    for (int i = 0; i < 5; i++) tick();
    check("R8 quiet", {63'd0, msg_req}, 64'd0);
    done_cnt = 15'd4; tick();
    check("R8 release rearms", {63'd0, msg_req}, 64'd1);
    ack();
    done_cnt = 15'd6; tick();
    check("R8 arrival rearms", {63'd0, msg_req}, 64'd1);
    ack();
    done_cnt = '0; tick();

    // R5: timeout path fires after timeout+1 edges
    wr(8'h00, 32'h0004_0064);
    wr(8'h04, 32'd4);
    done_cnt = 15'd3;
    for (int i = 0; i < 4; i++) tick();
    check("R5 early", {63'd0, msg_req}, 64'd0);
    tick();
    check("R5 on time", {63'd0, msg_req}, 64'd1);
    ack();
    done_cnt = '0; tick();

    // R7: return to zero restarts the wait
    done_cnt = 15'd3;
    for (int i = 0; i < 3; i++) tick();
    done_cnt = '0; tick();
    done_cnt = 15'd3;
    for (int i = 0; i < 4; i++) tick();
    check("R7 restarted", {63'd0, msg_req}, 64'd0);
    tick();
    check("R7 fires", {63'd0, msg_req}, 64'd1);
    ack();
    done_cnt = '0; tick();

    // R6: timer disabled never fires below the limit
    wr(8'h00, 32'd10);
    done_cnt = 15'd3;
    for (int i = 0; i < 20; i++) tick();
    check("R6 no timer", {63'd0, msg_req}, 64'd0);
    done_cnt = '0; tick();

    // R4: zero count with every path open
    wr(8'h00, 32'h0004_0000);
    wr(8'h04, 32'd0);
    for (int i = 0; i < 5; i++) tick();
    check("R4 zero", {63'd0, msg_req}, 64'd0);

    // R11: limit and timeout met together -> one message
    wr(8'h00, 32'h0004_0005);
    done_cnt = 15'd5; tick();
    check("R11 one", {63'd0, msg_req}, 64'd1);
    ack();
    for (int i = 0; i < 3; i++) tick();
    check("R11 no second", {63'd0, msg_req}, 64'd0);
    done_cnt = '0; tick();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule